// File: doc/BRIEF.md
# Sleep-Mode Edge Interrupt Recorder

This block is a secondary interrupt controller placed between external interrupt lines and a main interrupt controller that can lose power during sleep. While it is armed, it watches every source after a two-flop synchronizer. It captures each active edge into a sticky per-source status bit, so that no edge is lost while the main controller is off.

After wake-up, software issues a flush command. The block then replays every recorded, unmasked source toward the main controller as a single-cycle pulse and clears those status bits. Software programs per-source mask, trigger type and polarity through write-1 set/clear register pairs. It discards unwanted status through a write-1 acknowledge bank. Access is over a simple word-wide register bus. Reads are combinational in the same cycle, and writes take effect at the clock edge.

Top module: `sleep_edge_recorder`

## Requirements
- R1: Source n occupies bit (n mod 32) of the word at bank base + 4*(n div 32). The bank bases are: control 0x300, acknowledge/status 0x040, mask set 0x0C0 and clear 0x100, type set 0x180 and clear 0x1C0, polarity set 0x240 and clear 0x280.
- R2: A 1 written to a set bank sets that source's bit, and a 1 written to the matching clear bank clears it. Bits written as 0 leave the state unchanged. Reading a set address returns the current state word. After reset, mask reads all ones (masked), while type (1 = level, 0 = edge) and polarity (1 = rising, 0 = falling) read all zeros.
- R3: Control bit 0 is enable, bit 1 is edge-record mode and bit 2 is flush. Flush is self-clearing and reads as 0. Control reads 0 after reset.
- R4: With enable and edge-record mode both set, an edge of the programmed polarity on an unmasked edge-type source sets its status bit. Status is read at the acknowledge address.
- R5: An edge of the opposite polarity is never recorded. A level-type source is never recorded, and neither is a masked source.
- R6: When enable or edge-record mode is clear, no new status is recorded, and status already recorded holds its value.
- R7: A 1 written to an acknowledge bit clears that source's status bit. Zero bits have no effect. An acknowledge beats a new edge arriving in the same cycle.
- R8: Writing control with bit 2 set drives `replay_o` high for exactly one cycle, in the cycle after the write, for every recorded unmasked source, and clears those status bits. Recorded masked sources stay recorded.
- R9: `replay_o` is all zero in every cycle that does not follow a flush write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_re_i | input | 1 | Register read strobe |
| bus_addr_i | input | AW | Byte address of the register word |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the strobe cycle |
| irq_i | input | NUM_SRC | Asynchronous interrupt sources |
| replay_o | output | NUM_SRC | Single-cycle replay pulses toward the main controller |

## Verification
The bench places a source in the upper word, so a design that placed sources at the wrong bit or word would show status in the wrong register. It drives an edge of the wrong polarity, toggles a level-type source and a masked source, and toggles sources with only one of the two mode bits set. A recorder that ignored type, mask or arming would pick up these edges. A flush with one recorded source masked shows whether the masked bit is wrongly replayed or lost. It also shows whether the pulse is longer than one cycle, and whether the flushed bits fail to clear. An acknowledge of one bit, and an acknowledge written with all zeros, expose a recorder that clears too much.

// File: rtl/srec_pkg.sv
package srec_pkg;
  localparam int unsigned OFS_ACK  = 32'h040;
  localparam int unsigned OFS_MSET = 32'h0C0;
  localparam int unsigned OFS_MCLR = 32'h100;
  localparam int unsigned OFS_TSET = 32'h180;
  localparam int unsigned OFS_TCLR = 32'h1C0;
  localparam int unsigned OFS_PSET = 32'h240;
  localparam int unsigned OFS_PCLR = 32'h280;
  localparam int unsigned OFS_CTRL = 32'h300;
  localparam int unsigned CTL_EN    = 0;
  localparam int unsigned CTL_EDGE  = 1;
  localparam int unsigned CTL_FLUSH = 2;
  localparam int unsigned WORD_W    = 32;
endpackage

// File: rtl/srec_sync.sv
module srec_sync #(
  parameter int unsigned W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/srec_w1_bank.sv
module srec_w1_bank #(
  parameter int unsigned N       = 64,
  parameter bit          RST_VAL = 1'b0,
  localparam int unsigned NW     = (N + 31) / 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NW-1:0] set_we_i,
  input  logic [NW-1:0] clr_we_i,
  input  logic [31:0]   wdata_i,
  output logic [N-1:0]  state_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                state_o[i] <= RST_VAL;
      else if (set_we_i[i/32] && wdata_i[i%32])   state_o[i] <= 1'b1;
      else if (clr_we_i[i/32] && wdata_i[i%32])   state_o[i] <= 1'b0;
    end
  end

  // R2: no strobe, no change
  p_hold_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_we_i == '0 && clr_we_i == '0) |=> $stable(state_o));
endmodule

// File: rtl/srec_capture.sv
module srec_capture #(
  parameter int unsigned N = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  input  logic         rec_en_i,
  input  logic [N-1:0] mask_i,
  input  logic [N-1:0] level_i,
  input  logic [N-1:0] rise_i,
  input  logic [N-1:0] ack_i,
  input  logic         flush_i,
  output logic [N-1:0] status_o,
  output logic [N-1:0] replay_o
);
  logic [N-1:0] prev_q, hit, flush_sel, edge_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= src_i;
  end

  assign edge_seen = (rise_i & src_i & ~prev_q) | (~rise_i & ~src_i & prev_q);
  assign hit       = rec_en_i ? (edge_seen & ~mask_i & ~level_i) : '0;
  assign flush_sel = flush_i ? (status_o & ~mask_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_o <= '0;
      replay_o <= '0;
    end else begin
      status_o <= ((status_o & ~flush_sel) | hit) & ~ack_i;  // ack wins
      replay_o <= flush_sel;
    end
  end

  p_ack_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i != '0) |=> ((status_o & $past(ack_i)) == '0));
  p_idle_no_record_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rec_en_i |=> ((status_o & ~$past(status_o)) == '0));
  p_blocked_never_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_en_i |=> ((status_o & ~$past(status_o) & $past(mask_i | level_i)) == '0));
  p_replay_needs_flush_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (replay_o != '0) |-> $past(flush_i));
  p_pulse_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (replay_o != '0) |=> ((replay_o & $past(replay_o)) == '0));
endmodule

// File: rtl/sleep_edge_recorder.sv
module sleep_edge_recorder
  import srec_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned AW      = 12,
  localparam int unsigned NW     = (NUM_SRC + 31) / 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_we_i,
  input  logic               bus_re_i,
  input  logic [AW-1:0]      bus_addr_i,
  input  logic [31:0]        bus_wdata_i,
  output logic [31:0]        bus_rdata_o,
  input  logic [NUM_SRC-1:0] irq_i,
  output logic [NUM_SRC-1:0] replay_o
);
  localparam logic [AW-1:0] A_CTRL = AW'(OFS_CTRL);

  logic [NW-1:0] ack_we, mset_we, mclr_we, tset_we, tclr_we, pset_we, pclr_we;
  logic [NUM_SRC-1:0] ack_bits, mask_q, level_q, rise_q, status, src_s;
  logic ctl_en_q, ctl_edge_q, ctrl_we, flush;

  function automatic logic at(input logic [AW-1:0] a, input int unsigned base, input int unsigned w);
    return a == AW'(base + 4 * w);
  endfunction

  for (genvar w = 0; w < NW; w++) begin : g_dec
    assign ack_we[w]  = bus_we_i && at(bus_addr_i, OFS_ACK,  w);
    assign mset_we[w] = bus_we_i && at(bus_addr_i, OFS_MSET, w);
    assign mclr_we[w] = bus_we_i && at(bus_addr_i, OFS_MCLR, w);
    assign tset_we[w] = bus_we_i && at(bus_addr_i, OFS_TSET, w);
    assign tclr_we[w] = bus_we_i && at(bus_addr_i, OFS_TCLR, w);
    assign pset_we[w] = bus_we_i && at(bus_addr_i, OFS_PSET, w);
    assign pclr_we[w] = bus_we_i && at(bus_addr_i, OFS_PCLR, w);
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_ack
    assign ack_bits[i] = ack_we[i/32] && bus_wdata_i[i%32];
  end

  assign ctrl_we = bus_we_i && (bus_addr_i == A_CTRL);
  assign flush   = ctrl_we && bus_wdata_i[CTL_FLUSH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_en_q   <= 1'b0;
      ctl_edge_q <= 1'b0;
    end else if (ctrl_we) begin
      ctl_en_q   <= bus_wdata_i[CTL_EN];
      ctl_edge_q <= bus_wdata_i[CTL_EDGE];
    end
  end

  srec_w1_bank #(.N(NUM_SRC), .RST_VAL(1'b1)) u_mask (
    .clk_i, .rst_ni, .set_we_i(mset_we), .clr_we_i(mclr_we),
    .wdata_i(bus_wdata_i), .state_o(mask_q));
  srec_w1_bank #(.N(NUM_SRC), .RST_VAL(1'b0)) u_type (
    .clk_i, .rst_ni, .set_we_i(tset_we), .clr_we_i(tclr_we),
    .wdata_i(bus_wdata_i), .state_o(level_q));
  srec_w1_bank #(.N(NUM_SRC), .RST_VAL(1'b0)) u_pol (
    .clk_i, .rst_ni, .set_we_i(pset_we), .clr_we_i(pclr_we),
    .wdata_i(bus_wdata_i), .state_o(rise_q));

  srec_sync #(.W(NUM_SRC)) u_sync (.clk_i, .rst_ni, .d_i(irq_i), .q_o(src_s));

  srec_capture #(.N(NUM_SRC)) u_cap (
    .clk_i, .rst_ni, .src_i(src_s), .rec_en_i(ctl_en_q && ctl_edge_q),
    .mask_i(mask_q), .level_i(level_q), .rise_i(rise_q), .ack_i(ack_bits),
    .flush_i(flush), .status_o(status), .replay_o(replay_o));

  logic [NW*32-1:0] st_pad, mk_pad, lv_pad, rs_pad;
  always_comb begin
    st_pad = '0; st_pad[NUM_SRC-1:0] = status;
    mk_pad = '0; mk_pad[NUM_SRC-1:0] = mask_q;
    lv_pad = '0; lv_pad[NUM_SRC-1:0] = level_q;
    rs_pad = '0; rs_pad[NUM_SRC-1:0] = rise_q;
    bus_rdata_o = '0;
    if (bus_re_i) begin
      if (bus_addr_i == A_CTRL) bus_rdata_o = {30'd0, ctl_edge_q, ctl_en_q};
      for (int unsigned w = 0; w < NW; w++) begin
        if (at(bus_addr_i, OFS_ACK,  w)) bus_rdata_o = st_pad[w*32 +: 32];
        if (at(bus_addr_i, OFS_MSET, w)) bus_rdata_o = mk_pad[w*32 +: 32];
        if (at(bus_addr_i, OFS_TSET, w)) bus_rdata_o = lv_pad[w*32 +: 32];
        if (at(bus_addr_i, OFS_PSET, w)) bus_rdata_o = rs_pad[w*32 +: 32];
      end
    end
  end

  // R3: control write latches mode bits
  p_ctrl_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we |=> (ctl_en_q == $past(bus_wdata_i[CTL_EN])) && (ctl_edge_q == $past(bus_wdata_i[CTL_EDGE])));
endmodule

// File: tb/sleep_edge_recorder_test.sv
`timescale 1ns/1ps
module sleep_edge_recorder_test;
  localparam int N = 64;
  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0, re = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [N-1:0] src = '0, replay;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sleep_edge_recorder #(.NUM_SRC(N), .AW(12)) uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_re_i(re), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_i(src), .replay_o(replay));

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk); re = 1'b1; addr = a;
    #1; chk(tag, {32'd0, rdata}, {32'd0, exp});
    re = 1'b0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic toggle(input int idx);
    src[idx] = 1'b1; settle();
    src[idx] = 1'b0; settle();
  endtask

  task automatic flush_chk(input string tag, input logic [63:0] exp);
    @(negedge clk); we = 1'b1; addr = 12'h300; wdata = 32'h7;
    @(negedge clk); we = 1'b0; wdata = '0;
    chk({tag, " pulse"}, replay, exp);
    @(negedge clk);
    chk({tag, " single-cycle"}, replay, '0);
  endtask

  task automatic t_reset();
    rd_chk("R2 mask word0 reset", 12'h0C0, 32'hFFFF_FFFF);
    rd_chk("R2 mask word1 reset", 12'h0C4, 32'hFFFF_FFFF);
    rd_chk("R2 type reset", 12'h180, 32'h0);
    rd_chk("R2 polarity reset", 12'h244, 32'h0);
    rd_chk("R3 control reset", 12'h300, 32'h0);
    rd_chk("R4 status reset", 12'h040, 32'h0);
    chk("R9 replay reset", replay, '0);
  endtask

  task automatic t_config();
    wr(12'h100, 32'h0000_00FF);
    rd_chk("R2 clear bank", 12'h0C0, 32'hFFFF_FF00);
    wr(12'h0C0, 32'h0000_0001);
    rd_chk("R2 set bank", 12'h0C0, 32'hFFFF_FF01);
    wr(12'h0C0, 32'h0);
    wr(12'h100, 32'h0);
    rd_chk("R2 zero bits no effect", 12'h0C0, 32'hFFFF_FF01);
    wr(12'h100, 32'hFFFF_FFFF);
    wr(12'h104, 32'hFFFF_FFFF);
    rd_chk("R1 mask word1 cleared", 12'h0C4, 32'h0);
    wr(12'h240, 32'h0000_000F);
    rd_chk("R2 polarity set", 12'h240, 32'h0000_000F);
    wr(12'h300, 32'h3);
    rd_chk("R3 control armed", 12'h300, 32'h3);
  endtask

  task automatic t_record();
    src[0] = 1'b1; settle();
    rd_chk("R4 rising edge recorded", 12'h040, 32'h1);
    src[0] = 1'b0; settle();
    toggle(4);
    toggle(33);
    src[5] = 1'b1; settle();
    rd_chk("R5 wrong polarity ignored", 12'h040, 32'h11);
    rd_chk("R1 source 33 in word1 bit1", 12'h044, 32'h2);
    chk("R9 no replay while recording", replay, '0);
  endtask

  task automatic t_blocked();
    wr(12'h180, 32'h0000_0040);
    toggle(6);
    wr(12'h0C0, 32'h0000_0080);
    toggle(7);
    rd_chk("R5 level and masked ignored", 12'h040, 32'h11);
  endtask

  task automatic t_disarmed();
    wr(12'h300, 32'h1);
    toggle(8);
    rd_chk("R6 edge mode off", 12'h040, 32'h11);
    wr(12'h300, 32'h2);
    toggle(8);
    rd_chk("R6 enable off, status held", 12'h040, 32'h11);
    wr(12'h300, 32'h3);
  endtask

  task automatic t_ack();
    wr(12'h040, 32'h10);
    rd_chk("R7 ack clears one bit", 12'h040, 32'h01);
    wr(12'h044, 32'h0);
    rd_chk("R7 zero ack no effect", 12'h044, 32'h2);
  endtask

  task automatic t_flush();
    toggle(9);
    rd_chk("R4 source 9 recorded", 12'h040, 32'h201);
    wr(12'h0C0, 32'h0000_0200);
    flush_chk("R8 flush skips masked", 64'h0000_0002_0000_0001);
    rd_chk("R3 flush reads zero", 12'h300, 32'h3);
    rd_chk("R8 masked stays recorded", 12'h040, 32'h200);
    rd_chk("R8 flushed word1 cleared", 12'h044, 32'h0);
    wr(12'h100, 32'h0000_0200);
    flush_chk("R8 flush after unmask", 64'h0000_0000_0000_0200);
    rd_chk("R8 status empty", 12'h040, 32'h0);
    settle();
    chk("R9 idle replay", replay, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_config();
    t_record();
    t_blocked();
    t_disarmed();
    t_ack();
    t_flush();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule